// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two IEEE-754 operands, either both single precision or both double precision, under one of sixteen predicate codes. It returns one condition bit and an invalid-operation flag. A host pipeline presents the operand bit patterns, a format select and a 4-bit code with a valid strobe. One cycle later the block answers with a done pulse and a registered result. The result can then go into a condition register or to branch logic. That write is done outside this block.

The block finds NaN operands on its own. It treats positive and negative zero as equal and orders non-NaN values by sign and magnitude, so infinities sort at the two ends of the number line. The upper eight codes are signaling versions of the lower eight. When either operand is unordered they force the result low and raise the invalid flag.

Top module: `fcmp_unit`

## Requirements
- R1: `done_o` is high in exactly the cycle after each cycle in which `valid_i` is high, and low otherwise.
- R2: Predicate code 0 and code 8 always yield a false result.
- R3: Code 1 (unordered) yields true exactly when at least one operand is a NaN. A NaN has an all-ones exponent and a nonzero fraction. In single format the operand is bits [31:0], with the sign at bit 31, the exponent at [30:23] and the fraction at [22:0]. In double format the sign is at bit 63, the exponent at [62:52] and the fraction at [51:0]. An all-ones exponent with a zero fraction is an infinity and is not a NaN.
- R4: With a NaN operand, codes 2 (equal), 4 (less) and 6 (less-or-equal) yield false, and codes 3, 5 and 7 (their unordered forms) yield true.
- R5: Positive and negative zero compare equal: code 2 and code 6 are true and code 4 is false.
- R6: Non-NaN values are ordered by sign and magnitude. Any negative value is less than any positive value, and among negatives the one with the larger magnitude is less.
- R7: Negative infinity is less than every finite value, and positive infinity is greater than every finite value.
- R8: Without a NaN operand, codes 8 to 15 give the same result as the code minus 8, and `invalid_o` stays low.
- R9: With a NaN operand, codes 8 to 15 yield false and set `invalid_o`.
- R10: Codes 0 to 7 never set `invalid_o`.
- R11: In single format (`fmt_dbl_i` = 0), bits [63:32] of both operands have no effect.
- R12: After reset, `result_o`, `invalid_o` and `done_o` are low.
- R13: While `valid_i` is low, `result_o` and `invalid_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| fmt_dbl_i | input | 1 | 1 = double format, 0 = single format |
| cond_i | input | 4 | Predicate code |
| op_a_i | input | 64 | First operand bit pattern |
| op_b_i | input | 64 | Second operand bit pattern |
| result_o | output | 1 | Condition result |
| invalid_o | output | 1 | Invalid-operation flag |
| done_o | output | 1 | Result-valid pulse |

## Verification
The bench builds the block with its default field widths: an 8-bit exponent with a 23-bit fraction, and an 11-bit exponent with a 52-bit fraction. This lets it test real single and double encodings of ones, twos, signed zeros, infinities and quiet NaNs. With these widths the single-format path also sees junk in the upper word that must be ignored. The bench runs every predicate code against both ordered and unordered pairs, in both formats.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [2:0] {
    PRED_NEVER = 3'd0,
    PRED_UNORD = 3'd1,
    PRED_EQ    = 3'd2,
    PRED_UEQ   = 3'd3,
    PRED_LT    = 3'd4,
    PRED_ULT   = 3'd5,
    PRED_LE    = 3'd6,
    PRED_ULE   = 3'd7
  } pred_e;

  typedef struct packed {
    logic nan;
    logic sign;
  } op_class_t;
endpackage

// File: rtl/fcmp_field.sv
module fcmp_field #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MAG_W  = 63
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output fcmp_pkg::op_class_t   cls_o,
  output logic [MAG_W-1:0]      mag_o
);
  localparam int LMAG = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f      = word_i[LMAG-1:FRAC_W];
  assign frac_f     = word_i[FRAC_W-1:0];
  assign cls_o.nan  = (&exp_f) && (|frac_f);
  assign cls_o.sign = word_i[LMAG];

  generate
    if (MAG_W > LMAG) begin : g_pad
      assign mag_o = {{(MAG_W-LMAG){1'b0}}, word_i[LMAG-1:0]};
    end else begin : g_nopad
      assign mag_o = word_i[MAG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int MAG_W = 63
) (
  input  logic             sign_a_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output logic             eq_o,
  output logic             lt_o
);
  logic both_zero, mag_lt, mag_gt;

  assign both_zero = (mag_a_i == '0) && (mag_b_i == '0);
  assign mag_lt    = mag_a_i < mag_b_i;
  assign mag_gt    = mag_a_i > mag_b_i;

  always_comb begin
    eq_o = both_zero || (sign_a_i == sign_b_i && mag_a_i == mag_b_i);
    if (both_zero)                lt_o = 1'b0;
    else if (sign_a_i != sign_b_i) lt_o = sign_a_i;
    else if (sign_a_i)            lt_o = mag_gt;  // both negative: reversed
    else                          lt_o = mag_lt;
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
  parameter int EXP_S  = 8,
  parameter int FRAC_S = 23,
  parameter int EXP_D  = 11,
  parameter int FRAC_D = 52
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     fmt_dbl_i,
  input  logic [3:0]               cond_i,
  input  logic [EXP_D+FRAC_D:0]    op_a_i,
  input  logic [EXP_D+FRAC_D:0]    op_b_i,
  output logic                     result_o,
  output logic                     invalid_o,
  output logic                     done_o
);
  import fcmp_pkg::*;

  localparam int W_S   = 1 + EXP_S + FRAC_S;
  localparam int W_D   = 1 + EXP_D + FRAC_D;
  localparam int MAG_W = EXP_D + FRAC_D;

  op_class_t        cls_s [2];
  op_class_t        cls_d [2];
  op_class_t        cls   [2];
  logic [MAG_W-1:0] mag_s [2];
  logic [MAG_W-1:0] mag_d [2];
  logic [MAG_W-1:0] mag   [2];
  logic [W_D-1:0]   ops   [2];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar i = 0; i < 2; i++) begin : g_op
    fcmp_field #(.EXP_W(EXP_S), .FRAC_W(FRAC_S), .MAG_W(MAG_W)) u_fs (
      .word_i(ops[i][W_S-1:0]), .cls_o(cls_s[i]), .mag_o(mag_s[i]));
    fcmp_field #(.EXP_W(EXP_D), .FRAC_W(FRAC_D), .MAG_W(MAG_W)) u_fd (
      .word_i(ops[i]), .cls_o(cls_d[i]), .mag_o(mag_d[i]));
    assign cls[i] = fmt_dbl_i ? cls_d[i] : cls_s[i];
    assign mag[i] = fmt_dbl_i ? mag_d[i] : mag_s[i];
  end

  logic ord_eq, ord_lt;
  fcmp_order #(.MAG_W(MAG_W)) u_ord (
    .sign_a_i(cls[0].sign), .mag_a_i(mag[0]),
    .sign_b_i(cls[1].sign), .mag_b_i(mag[1]),
    .eq_o(ord_eq), .lt_o(ord_lt));

  logic  unord, sig_trap, res_d;
  pred_e base;

  assign base     = pred_e'(cond_i[2:0]);
  assign unord    = cls[0].nan || cls[1].nan;
  assign sig_trap = cond_i[3] && unord;

  // code bit0: true when unordered; bit1: equal; bit2: less
  always_comb begin
    if (sig_trap)   res_d = 1'b0;
    else if (unord) res_d = base[0];
    else            res_d = (base[1] && ord_eq) || (base[2] && ord_lt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= 1'b0;
      invalid_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        invalid_o <= sig_trap;
      end
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_done_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  p_never_true_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i[2:0] == 3'd0) |=> !result_o);
  p_order_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ord_eq && ord_lt));
  p_trap_false_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !result_o);
  p_quiet_no_inv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_i[3]) |=> !invalid_o);
  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(invalid_o)));
endmodule

// File: tb/sim_fcmp_unit.sv
`timescale 1ns/1ps
module sim_fcmp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        fmt_dbl_i = 1'b0;
  logic [3:0]  cond_i = 4'd0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic        result_o, invalid_o, done_o;
  int n_run = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  fcmp_unit u0 (.*);

  localparam logic [63:0] S_ONE = 64'h3F800000, S_TWO = 64'h40000000,
    S_M1 = 64'hBF800000, S_M2 = 64'hC0000000, S_PZ = 64'h0, S_NZ = 64'h80000000,
    S_PINF = 64'h7F800000, S_NINF = 64'hFF800000, S_NAN = 64'h7FC00000;
  localparam logic [63:0] D_ONE = 64'h3FF0000000000000, D_TWO = 64'h4000000000000000,
    D_M1 = 64'hBFF0000000000000, D_M2 = 64'hC000000000000000,
    D_NAN = 64'h7FF8000000000000, D_INF = 64'h7FF0000000000000,
    D_NZ = 64'h8000000000000000;

  task automatic chk(string req, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic cmp(string req, logic dbl, logic [3:0] c, logic [63:0] a,
                     logic [63:0] b, logic exp_r, logic exp_i);
    @(negedge clk_i);
    fmt_dbl_i = dbl; cond_i = c; op_a_i = a; op_b_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " done"}, done_o, 1'b1);
    chk({req, " result"}, result_o, exp_r);
    chk({req, " invalid"}, invalid_o, exp_i);
  endtask

  task automatic t_reset_r12();
    chk("R12 result", result_o, 1'b0);
    chk("R12 invalid", invalid_o, 1'b0);
    chk("R12 done", done_o, 1'b0);
  endtask

  task automatic t_false_r2();
    cmp("R2 c0", 0, 4'd0, S_ONE, S_ONE, 0, 0);
    cmp("R2 c8", 1, 4'd8, D_ONE, D_ONE, 0, 0);
  endtask

  task automatic t_unord_r3();
    cmp("R3 nan", 0, 4'd1, S_NAN, S_ONE, 1, 0);
    cmp("R3 ord", 0, 4'd1, S_ONE, S_TWO, 0, 0);
    cmp("R3 inf", 0, 4'd1, S_PINF, S_ONE, 0, 0);
    cmp("R3 dnan", 1, 4'd1, D_ONE, D_NAN, 1, 0);
    cmp("R3 dinf", 1, 4'd1, D_INF, D_ONE, 0, 0);
  endtask

  task automatic t_nan_r4();
    for (int c = 2; c < 8; c++)
      cmp("R4", 0, 4'(c), S_ONE, S_NAN, c[0], 0);
  endtask

  task automatic t_zero_r5();
    cmp("R5 eq", 0, 4'd2, S_PZ, S_NZ, 1, 0);
    cmp("R5 le", 0, 4'd6, S_NZ, S_PZ, 1, 0);
    cmp("R5 lt", 0, 4'd4, S_NZ, S_PZ, 0, 0);
    cmp("R5 deq", 1, 4'd2, D_NZ, 64'h0, 1, 0);
  endtask

  task automatic t_order_r6();
    cmp("R6 neg<pos", 0, 4'd4, S_M1, S_ONE, 1, 0);
    cmp("R6 pos<neg", 0, 4'd4, S_ONE, S_M1, 0, 0);
    cmp("R6 -2<-1", 0, 4'd4, S_M2, S_M1, 1, 0);
    cmp("R6 -1<-2", 0, 4'd4, S_M1, S_M2, 0, 0);
    cmp("R6 1<2", 0, 4'd4, S_ONE, S_TWO, 1, 0);
    cmp("R6 d -2<-1", 1, 4'd4, D_M2, D_M1, 1, 0);
    cmp("R6 d 2<=1", 1, 4'd6, D_TWO, D_ONE, 0, 0);
    cmp("R6 eq ne", 0, 4'd2, S_ONE, S_TWO, 0, 0);
  endtask

  task automatic t_inf_r7();
    cmp("R7 ninf", 0, 4'd4, S_NINF, S_M2, 1, 0);
    cmp("R7 pinf", 0, 4'd4, S_TWO, S_PINF, 1, 0);
    cmp("R7 pinf gt", 0, 4'd6, S_PINF, S_TWO, 0, 0);
  endtask

  task automatic t_sig_r8_r9();
    cmp("R8 c12", 0, 4'd12, S_ONE, S_TWO, 1, 0);
    cmp("R8 c10", 1, 4'd10, D_ONE, D_ONE, 1, 0);
    cmp("R8 c15", 0, 4'd15, S_TWO, S_ONE, 0, 0);
    for (int c = 8; c < 16; c++)
      cmp("R9", 0, 4'(c), S_NAN, S_ONE, 0, 1);
    cmp("R9 d", 1, 4'd11, D_NAN, D_ONE, 0, 1);
  endtask

  task automatic t_quiet_r10();
    cmp("R10 c7", 1, 4'd7, D_NAN, D_NAN, 1, 0);
  endtask

  task automatic t_upper_r11();
    cmp("R11 eq", 0, 4'd2, {32'h7FF80000, 32'h3F800000}, S_ONE, 1, 0);
    cmp("R11 un", 0, 4'd1, {32'hFFFFFFFF, 32'h3F800000}, {32'h12345678, 32'h40000000}, 0, 0);
  endtask

  task automatic t_hold_r13();
    cmp("R13 set", 0, 4'd9, S_NAN, S_NAN, 0, 1);
    cmp("R13 set2", 0, 4'd3, S_NAN, S_NAN, 1, 0);
    @(negedge clk_i);
    cond_i = 4'd0; op_a_i = S_NAN;
    @(negedge clk_i);
    chk("R13 result", result_o, 1'b1);
    chk("R13 invalid", invalid_o, 1'b0);
    chk("R1 no done", done_o, 1'b0);
  endtask

  initial begin
    fork
      begin
        #3;
        t_reset_r12();
        #10 rst_ni = 1'b1;
        t_false_r2();
        t_unord_r3();
        t_nan_r4();
        t_zero_r5();
        t_order_r6();
        t_inf_r7();
        t_sig_r8_r9();
        t_quiet_r10();
        t_upper_r11();
        t_hold_r13();
      end
      begin
        #1000000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule